// File: doc/BRIEF.md
# Capture Compare PWM Unit

This peripheral works beside a free-running 16-bit timer and an 8-bit period timer, both supplied from outside. A 4-bit mode field in its control register selects one of three jobs. In capture mode it stores the 16-bit timer value into its register pair when a chosen edge pattern appears on the pin input. In compare mode it watches the 16-bit timer for equality with the register pair. On a match it can set the output pin, clear it, only raise the interrupt flag, or emit a one-cycle special-event trigger. In PWM mode it drives the pin with a 10-bit duty cycle measured against the period timer, which is extended by a 2-bit fine phase counted inside the unit.

Software writes the control byte and the two halves of the register pair through simple write strobes. It clears the sticky interrupt flag with a pulse. The register pair is always visible on an output so captured values can be read.

Top module: `ccp_unit`

## Requirements
- R1: After reset the mode is off (0000), the pin output, interrupt flag and trigger are 0, and the register pair reads 0.
- R2: In mode 0000, and in the unassigned codes 0001 to 0011, pin activity captures nothing, no flag is raised and the pin output stays 0.
- R3: Mode 0100 captures on a falling edge and mode 0101 on a rising edge. An edge is a change between the pin samples of two consecutive clocks. The register pair takes the timer value present at that edge, and a capture beats a software write in the same cycle.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge.
- R5: Any control write clears the edge prescaler, so the count of rising edges starts again from zero.
- R6: Mode 1000 drives the pin high on a match and mode 1001 drives it low on a match. A control write presets the pin high when the new mode is 1001 and low for every other mode.
- R7: A compare match is one event, raised in the cycle the timer first equals the register pair. It does not repeat while the two stay equal.
- R8: Mode 1010 raises only the flag and leaves the pin unchanged. Mode 1011 raises the flag and a trigger pulse exactly one clock long.
- R9: The interrupt flag is set by a capture or a compare match and stays set until the clear input is pulsed. A set in the same cycle as a clear wins.
- R10: Any mode 11xx selects PWM. The duty is {register-pair low byte, control bits 5:4}. At the period-start pulse the pin goes high if the duty is nonzero. It goes low once {period timer, fine phase} reaches the duty. The fine phase is 0 in the start cycle and advances by one on each clock after it.
- R11: A new duty value takes effect only at the next period start, and once the pin has gone low it stays low until that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: [3:0] mode, [5:4] duty fine bits |
| lo_we | input | 1 | Register pair low byte write strobe |
| hi_we | input | 1 | Register pair high byte write strobe |
| wr_data | input | 8 | Data for register pair writes |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_val | input | 16 | Free-running timer value |
| per_tmr | input | 8 | Period timer value |
| per_start | input | 1 | Period-start pulse of the period timer |
| cap_in | input | 1 | Pin input for capture |
| ccp_pin | output | 1 | Pin output (compare or PWM) |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_trig | output | 1 | Special-event trigger pulse |
| pair_val | output | 16 | Register pair contents |

## Verification
The hardest state to reach is the prescaled capture after a control write arrives partway through an edge count. Only a reset of the counter exposes that case, and it shows as a capture on the 4th edge after the write rather than on an earlier one. The stimulus runs two rising edges in mode 0110, rewrites the mode, and then pulses the pin four more times while a behavioural model predicts every cycle. Compare windows are made by loading a target ahead of a timer that holds each value for two clocks, so each match is exposed to the single-event rule. PWM duty is changed mid-period to show the deferred update.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [3:0] MODE_OFF   = 4'b0000;
  localparam logic [3:0] CAP_FALL   = 4'b0100;
  localparam logic [3:0] CAP_RISE   = 4'b0101;
  localparam logic [3:0] CAP_DIV_S  = 4'b0110;
  localparam logic [3:0] CAP_DIV_L  = 4'b0111;
  localparam logic [3:0] CMP_SET    = 4'b1000;
  localparam logic [3:0] CMP_CLR    = 4'b1001;
  localparam logic [3:0] CMP_FLAG   = 4'b1010;
  localparam logic [3:0] CMP_TRIG   = 4'b1011;

  function automatic logic is_capture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_compare(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic is_pwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_capture_det.sv
module ccp_capture_det #(
  parameter int DIV_S = 4,
  parameter int DIV_L = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       ctl_we,
  input  logic       pin,
  output logic       cap_ev
);
  import ccp_pkg::*;
  localparam int PS_W = $clog2(DIV_L);
  localparam logic [PS_W-1:0] LAST_S = PS_W'(DIV_S - 1);
  localparam logic [PS_W-1:0] LAST_L = PS_W'(DIV_L - 1);

  logic            pin_q;
  logic [PS_W-1:0] ps_q, ps_d;
  logic            rise, fall, div_mode, ps_full, ps_en;

  always_comb begin
    rise     = pin & ~pin_q;
    fall     = ~pin & pin_q;
    div_mode = (mode == CAP_DIV_S) || (mode == CAP_DIV_L);
    ps_full  = (mode == CAP_DIV_S) ? (ps_q == LAST_S) : (ps_q == LAST_L);
    cap_ev   = ((mode == CAP_FALL) && fall) ||
               ((mode == CAP_RISE) && rise) ||
               (div_mode && rise && ps_full);
    ps_en    = ctl_we || (div_mode && rise);
    if (ctl_we)       ps_d = '0;
    else if (ps_full) ps_d = '0;
    else              ps_d = ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      ps_q  <= '0;
    end else begin
      pin_q <= pin;
      if (ps_en) ps_q <= ps_d;
    end
  end

  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ps_q == '0)); // R5
endmodule

// File: rtl/ccp_compare_det.sv
module ccp_compare_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] tmr,
  output logic         hit
);
  logic eq, eq_q;

  always_comb begin
    eq  = (ref_val == tmr);
    hit = eq & ~eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R7
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int TW = 8,
  parameter int FW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   per_tmr,
  input  logic            start,
  input  logic [TW+FW-1:0] duty_nxt,
  output logic            pwm_o
);
  localparam int DW = TW + FW;

  logic [FW-1:0] fine_q, fine_d;
  logic [DW-1:0] duty_q, duty_d;
  logic          pwm_q, pwm_d;
  logic [DW-1:0] cnt;

  always_comb begin
    cnt    = {per_tmr, fine_q};
    duty_d = duty_q;
    pwm_d  = pwm_q;
    if (start) begin
      fine_d = FW'(1);
      duty_d = duty_nxt;
      pwm_d  = |duty_nxt;
    end else begin
      fine_d = fine_q + 1'b1;
      if (pwm_q && (cnt >= duty_q)) pwm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      fine_q <= fine_d;
      if (start) duty_q <= duty_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !pwm_q) |=> !pwm_q); // R11
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(duty_q)); // R11
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit #(
  parameter int TMR_W  = 16,
  parameter int PER_W  = 8,
  parameter int FINE_W = 2,
  parameter int DIV_S  = 4,
  parameter int DIV_L  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [7:0]       wr_data,
  input  logic             flag_clr,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic [PER_W-1:0] per_tmr,
  input  logic             per_start,
  input  logic             cap_in,
  output logic             ccp_pin,
  output logic             irq_flag,
  output logic             evt_trig,
  output logic [TMR_W-1:0] pair_val
);
  import ccp_pkg::*;
  localparam int HI_W = TMR_W - 8;

  logic rs1_q, rs2_q, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic [3:0]        mode_q, mode_d;
  logic [FINE_W-1:0] dlsb_q, dlsb_d;
  logic [TMR_W-1:0]  pair_q, pair_d;
  logic              cmp_q, cmp_d, flag_q, flag_d, trig_q, trig_d;
  logic              cap_ev, hit, pwm_o, cap_take, cmp_hit, pair_en;

  ccp_capture_det #(.DIV_S(DIV_S), .DIV_L(DIV_L)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .mode(mode_q), .ctl_we(ctl_we),
    .pin(cap_in), .cap_ev(cap_ev));

  ccp_compare_det #(.W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_i_n), .ref_val(pair_q), .tmr(tmr_val), .hit(hit));

  ccp_pwm #(.TW(PER_W), .FW(FINE_W)) u_pwm (
    .clk(clk), .rst_n(rst_i_n), .per_tmr(per_tmr), .start(per_start),
    .duty_nxt({pair_q[PER_W-1:0], dlsb_q}), .pwm_o(pwm_o));

  always_comb begin
    cap_take = is_capture(mode_q) && cap_ev;
    cmp_hit  = is_compare(mode_q) && hit;
    pair_en  = cap_take || lo_we || hi_we;
    pair_d   = pair_q;
    if (cap_take) pair_d = tmr_val;
    else begin
      if (lo_we) pair_d[7:0] = wr_data;
      if (hi_we) pair_d[TMR_W-1:8] = wr_data[HI_W-1:0];
    end
    mode_d = ctl_wdata[3:0];
    dlsb_d = ctl_wdata[4 +: FINE_W];
    cmp_d  = cmp_q;
    if (ctl_we)                            cmp_d = (ctl_wdata[3:0] == CMP_CLR);
    else if (cmp_hit && mode_q == CMP_SET) cmp_d = 1'b1;
    else if (cmp_hit && mode_q == CMP_CLR) cmp_d = 1'b0;
    if (cap_take || cmp_hit) flag_d = 1'b1;
    else if (flag_clr)       flag_d = 1'b0;
    else                     flag_d = flag_q;
    trig_d = cmp_hit && (mode_q == CMP_TRIG);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q <= MODE_OFF;
      dlsb_q <= '0;
      pair_q <= '0;
      cmp_q  <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        mode_q <= mode_d;
        dlsb_q <= dlsb_d;
      end
      if (pair_en) pair_q <= pair_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign ccp_pin  = is_pwm(mode_q) ? pwm_o : cmp_q;
  assign irq_flag = flag_q;
  assign evt_trig = trig_q;
  assign pair_val = pair_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_q == MODE_OFF) |-> !ccp_pin); // R2
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    cap_take |=> (pair_val == $past(tmr_val))); // R3
  AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt_trig |-> irq_flag); // R8
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt_trig |=> !evt_trig); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_flag && !flag_clr) |=> irq_flag); // R9
endmodule

// File: tb/ccp_unit_tb.sv
module ccp_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PER_TICKS  = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we, lo_we, hi_we, flag_clr, per_start, cap_in;
  logic [7:0]  ctl_wdata, wr_data, per_tmr;
  logic [15:0] tmr_val;
  logic        ccp_pin, irq_flag, evt_trig;
  logic [15:0] pair_val;

  int checks = 0, failures = 0, cycles = 0, trig_seen = 0;
  int tcnt = 0, ph = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ccp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .lo_we(lo_we), .hi_we(hi_we), .wr_data(wr_data), .flag_clr(flag_clr),
    .tmr_val(tmr_val), .per_tmr(per_tmr), .per_start(per_start),
    .cap_in(cap_in), .ccp_pin(ccp_pin), .irq_flag(irq_flag),
    .evt_trig(evt_trig), .pair_val(pair_val));

  // behavioural reference model
  int m_mode, m_dlsb, m_pair, m_cmp, m_flag, m_trig, m_prev, m_ps, m_eqp;
  int m_fine, m_duty, m_pwm, m_rs1, m_rs2;

  task automatic m_reset();
    m_mode = 0; m_dlsb = 0; m_pair = 0; m_cmp = 0; m_flag = 0; m_trig = 0;
    m_prev = 0; m_ps = 0; m_eqp = 0; m_fine = 0; m_duty = 0; m_pwm = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset(); m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (!m_rs2) m_reset();
      else begin
        int rise, fall, full, ev, eq, hit, cnt, shadow;
        int n_pair, n_cmp, n_ps;
        rise = (cap_in && !m_prev);
        fall = (!cap_in && m_prev);
        full = (m_mode == 6) ? (m_ps == 3) : (m_ps == 15);
        ev = (m_mode == 4 && fall) || (m_mode == 5 && rise) ||
             ((m_mode == 6 || m_mode == 7) && rise && full);
        eq = (m_pair == int'(tmr_val));
        hit = eq && !m_eqp && (m_mode >= 8 && m_mode <= 11);
        n_pair = m_pair;
        if (ev) n_pair = tmr_val;
        else begin
          if (lo_we) n_pair = (n_pair & 16'hFF00) | wr_data;
          if (hi_we) n_pair = (n_pair & 16'h00FF) | (int'(wr_data) << 8);
        end
        n_ps = m_ps;
        if (ctl_we) n_ps = 0;
        else if ((m_mode == 6 || m_mode == 7) && rise) n_ps = full ? 0 : m_ps + 1;
        n_cmp = m_cmp;
        if (ctl_we) n_cmp = (ctl_wdata[3:0] == 4'd9);
        else if (hit && m_mode == 8) n_cmp = 1;
        else if (hit && m_mode == 9) n_cmp = 0;
        if (ev || hit) m_flag = 1; else if (flag_clr) m_flag = 0;
        m_trig = hit && (m_mode == 11);
        cnt = int'(per_tmr) * 4 + m_fine;
        shadow = (m_pair & 8'hFF) * 4 + m_dlsb;
        if (per_start) begin
          m_duty = shadow; m_pwm = (shadow != 0); m_fine = 1;
        end else begin
          if (m_pwm && cnt >= m_duty) m_pwm = 0;
          m_fine = (m_fine + 1) % 4;
        end
        if (ctl_we) begin
          m_mode = ctl_wdata[3:0]; m_dlsb = ctl_wdata[5:4];
        end
        m_prev = cap_in; m_eqp = eq; m_pair = n_pair; m_ps = n_ps; m_cmp = n_cmp;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "pin", ccp_pin, (m_mode >= 12) ? m_pwm : m_cmp);
    chk(cur_req, "flag", irq_flag, m_flag);
    chk(cur_req, "trig", evt_trig, m_trig);
    chk(cur_req, "pair", pair_val, m_pair);
    if (evt_trig) trig_seen++;
    tcnt++;
    ph = (ph + 1) % PER_TICKS;
    tmr_val   = 16'(tcnt / 2);
    per_tmr   = 8'(ph / 4);
    per_start = (ph == 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wdata = v; ctl_we = 1; tick(); ctl_we = 0;
  endtask

  task automatic wr_pair(logic [15:0] v);
    wr_data = v[15:8]; hi_we = 1; tick(); hi_we = 0;
    wr_data = v[7:0];  lo_we = 1; tick(); lo_we = 0;
  endtask

  task automatic pin_pulse();
    cap_in = 1; run(2); cap_in = 0; run(2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; ctl_we = 0; lo_we = 0; hi_we = 0; flag_clr = 0; cap_in = 0;
    ctl_wdata = 0; wr_data = 0; tmr_val = 0; per_tmr = 0; per_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(4);
    chk("R1", "reset pin", ccp_pin, 0);
    chk("R1", "reset flag", irq_flag, 0);
    chk("R1", "reset trig", evt_trig, 0);
    chk("R1", "reset pair", pair_val, 0);

    cur_req = "R2";
    pin_pulse(); pin_pulse();
    wr_ctl(8'h02); pin_pulse(); pin_pulse();
    chk("R2", "off flag", irq_flag, 0);
    chk("R2", "off pair", pair_val, 0);

    cur_req = "R3";
    wr_pair(16'h1234);
    wr_ctl(8'h04); run(3); pin_pulse(); pin_pulse();
    chk("R3", "fall capture flag", irq_flag, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    wr_ctl(8'h05); run(3); pin_pulse();
    // capture beats a write in the same cycle
    cap_in = 1; wr_data = 8'hAA; lo_we = 1; tick(); lo_we = 0; run(3); cap_in = 0; run(2);

    cur_req = "R4";
    flag_clr = 1; tick(); flag_clr = 0;
    wr_ctl(8'h06);
    for (int k = 0; k < 9; k++) pin_pulse();
    wr_ctl(8'h07);
    for (int k = 0; k < 20; k++) pin_pulse();

    cur_req = "R5";
    wr_ctl(8'h06); pin_pulse(); pin_pulse();
    flag_clr = 1; tick(); flag_clr = 0;
    wr_ctl(8'h06);
    for (int k = 0; k < 3; k++) pin_pulse();
    chk("R5", "no capture before 4th edge", irq_flag, 0);
    pin_pulse();
    chk("R5", "capture on 4th edge after write", irq_flag, 1);

    cur_req = "R9";
    flag_clr = 1; tick(); flag_clr = 0;
    wr_ctl(8'h05);
    cap_in = 1; flag_clr = 1; tick(); flag_clr = 0; run(2);
    chk("R9", "set beats clear", irq_flag, 1);
    cap_in = 0; run(2); flag_clr = 1; tick(); flag_clr = 0;
    chk("R9", "cleared", irq_flag, 0);

    cur_req = "R6";
    wr_ctl(8'h08);
    wr_pair(tmr_val + 16'd20); run(50);
    chk("R6", "set on match", ccp_pin, 1);
    wr_ctl(8'h09);
    chk("R6", "preset high", ccp_pin, 1);
    wr_pair(tmr_val + 16'd20); run(50);
    chk("R6", "clear on match", ccp_pin, 0);

    cur_req = "R7";
    flag_clr = 1; tick(); flag_clr = 0;
    wr_ctl(8'h0A);
    wr_pair(tmr_val + 16'd10); run(19);
    flag_clr = 1; tick(); flag_clr = 0; run(3);

    cur_req = "R8";
    chk("R8", "flag-only keeps pin", ccp_pin, 0);
    trig_seen = 0;
    wr_ctl(8'h0B);
    wr_pair(tmr_val + 16'd15); run(50);
    chk("R8", "one trigger pulse", trig_seen, 1);

    cur_req = "R10";
    wr_pair(16'h0005);
    wr_ctl(8'h2C); run(200);
    wr_pair(16'h0000); wr_ctl(8'h0C); run(130);
    wr_pair(16'h00FF); wr_ctl(8'h3F); run(130);

    cur_req = "R11";
    wr_pair(16'h0003); wr_ctl(8'h1C); run(70);
    while (ph != 30) tick();
    wr_pair(16'h000A); run(100);
    wr_ctl(8'h00); run(4);

    summary();
  end
endmodule